// File: doc/BRIEF.md
# Window watchdog timer

This block supervises software by means of a 7-bit down-counter. Software must refresh the counter inside a time window. If it refreshes too late, the counter drops below 0x40. If it refreshes too early, the counter is still above a programmed window value. In either case the block issues a one-clock reset request. The counter is clocked from the bus clock through a fixed divider, followed by a divide of 1, 2, 4 or 8 chosen by a two-bit time-base field. The counter runs all the time, whether or not supervision is on.

Software uses a plain register port with three registers:

- **Control register:** a one-way enable bit and the counter value. Writing this register is the refresh.
- **Configuration register:** the window value, the time-base select and an early-warning interrupt enable.
- **Status register:** the early-warning flag, which is set as the counter reaches 0x40.

On a reset request the block returns itself to its power-up state.

Top module: `winwdt_top`

## Requirements
- R1: After reset the control register reads 0x007F (enable clear, counter 0x7F), the configuration register reads 0x007F, the status register reads 0, and `rst_req` and `irq` are low.
- R2: The counter falls by one every FIXED_DIV·2^tb bus clocks, where tb is configuration bits 8:7. Time is counted from the last control write.
- R3: The counter wraps from 0x00 to 0x7F and keeps counting. While the enable is clear, it never raises `rst_req`.
- R4: The enable sits in control bit 7. Writing 1 sets it, and writing 0 leaves it unchanged.
- R5: While enabled, the tick that takes the counter from 0x40 to 0x3F raises `rst_req` for exactly one clock, starting at that same clock edge.
- R6: While enabled, a control write with the counter above the window value (configuration bits 6:0) raises `rst_req`.
- R7: A control write that does not trigger a reset request loads bits 6:0 into the counter and restarts the prescaler, so the next decrement comes a full period later.
- R8: A control write that leaves the block enabled with bit 6 of the written value clear raises `rst_req`. While disabled, such a write only loads the counter.
- R9: The clock edge that raises `rst_req` also returns every register to its R1 value.
- R10: Status bit 0 is set when the counter ticks from 0x41 to 0x40. Writing 0 to it clears it, and writing 1 has no effect.
- R11: `irq` equals status bit 0 AND the interrupt enable in configuration bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | 2 | Register select: 0 control, 1 configuration, 2 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-clock system reset request |
| irq | output | 1 | Early-warning interrupt |

## Verification
A wrong prescaler or counter state shows at the control read port within one tick period. The decrement arrives one clock early or late, or carries the wrong value, and the bench samples on both sides of every expected edge. A wrong enable or window state shows as a missing or spurious `rst_req` in the very clock after the refresh write. A wrong flag state shows on `irq` and the status read at once, because both are combinational from the flag register.

// File: rtl/winwdt_pkg.sv
package winwdt_pkg;
   localparam int ADDR_W = 2;
   typedef enum logic [ADDR_W-1:0] {
      REG_CTRL = 2'd0,
      REG_CFG  = 2'd1,
      REG_STAT = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic ctrl;
      logic cfg;
      logic stat;
   } wr_dec_t;
endpackage

// File: rtl/winwdt_tick.sv
module winwdt_tick #(
   parameter int FIXED_DIV = 4096,
   parameter int TB_W      = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   input  logic [TB_W-1:0] tb,
   output logic            tick
);
   localparam int MAX_SHIFT = (1 << TB_W) - 1;
   localparam int MAX_DIV   = FIXED_DIV * (1 << MAX_SHIFT);
   localparam int PRE_W     = $clog2(MAX_DIV + 1);

   if (FIXED_DIV < 1) begin : g_bad_div
      $error("winwdt_tick: FIXED_DIV must be at least 1");
   end
   if (TB_W < 1 || TB_W > 3) begin : g_bad_tb
      $error("winwdt_tick: TB_W must be 1 to 3");
   end

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] term;

   assign term = (PRE_W'(FIXED_DIV) << tb) - 1'b1;
   assign tick = (pre_q == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pre_q <= '0;
      else if (restart)  pre_q <= '0;
      else if (tick)     pre_q <= '0;
      else               pre_q <= pre_q + 1'b1;
   end

   assert_pre_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pre_q <= PRE_W'(MAX_DIV - 1));
endmodule

// File: rtl/winwdt_count.sv
module winwdt_count #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt
);
   if (CNT_W < 3) begin : g_bad_w
      $error("winwdt_count: CNT_W must be at least 3");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '1;
      else if (clr)    cnt_q <= '1;
      else if (load)   cnt_q <= load_val;
      else if (tick)   cnt_q <= cnt_q - 1'b1;
   end

   assign cnt = cnt_q;

   // R2 and R3: a plain tick decrements modulo 2^CNT_W
   assert_dec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !clr && !load) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
   assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clr) |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/winwdt_regs.sv
module winwdt_regs #(
   parameter int CNT_W = 7,
   parameter int TB_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en_set,
   input  logic             cfg_wr,
   input  logic [CNT_W-1:0] cfg_win,
   input  logic [TB_W-1:0]  cfg_tb,
   input  logic             cfg_ewi,
   input  logic             stat_wr,
   input  logic             stat_bit,
   input  logic             flag_set,
   output logic             en,
   output logic [CNT_W-1:0] win,
   output logic [TB_W-1:0]  tb,
   output logic             ewi,
   output logic             flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en <= 1'b0; win <= '1; tb <= '0; ewi <= 1'b0; flag <= 1'b0;
      end else if (clr) begin
         en <= 1'b0; win <= '1; tb <= '0; ewi <= 1'b0; flag <= 1'b0;
      end else begin
         if (en_set) en <= 1'b1;
         if (cfg_wr) begin
            win <= cfg_win;
            tb  <= cfg_tb;
            ewi <= cfg_ewi;
         end
         if (flag_set)                   flag <= 1'b1;
         else if (stat_wr && !stat_bit)  flag <= 1'b0;
      end
   end

   assert_en_oneway_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en) |-> $past(clr));
   assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> ($past(clr) || $past(stat_wr)));
endmodule

// File: rtl/winwdt_top.sv
module winwdt_top #(
   parameter int FIXED_DIV = 4096,
   parameter int CNT_W     = 7,
   parameter int TB_W      = 2,
   parameter int DATA_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              rst_req,
   output logic              irq
);
   import winwdt_pkg::*;

   localparam int EN_BIT  = CNT_W;
   localparam int TB_LSB  = CNT_W;
   localparam int EWI_BIT = CNT_W + TB_W;
   localparam int USED_W  = EWI_BIT + 1;
   localparam logic [CNT_W-1:0] LOW_EDGE  = CNT_W'(1) << (CNT_W - 1);
   localparam logic [CNT_W-1:0] WARN_EDGE = LOW_EDGE + 1'b1;

   if (DATA_W < USED_W) begin : g_bad_data
      $error("winwdt_top: DATA_W too narrow for the configuration fields");
   end

   wr_dec_t          wr;
   logic             tick, fire, en, ewi, flag, en_next;
   logic             too_early, low_load, timeout, flag_set;
   logic [CNT_W-1:0] cnt, win;
   logic [TB_W-1:0]  tb;

   assign wr.ctrl = bus_wr && (bus_addr == REG_CTRL);
   assign wr.cfg  = bus_wr && (bus_addr == REG_CFG);
   assign wr.stat = bus_wr && (bus_addr == REG_STAT);

   assign en_next   = en | (wr.ctrl & bus_wdata[EN_BIT]);
   assign too_early = wr.ctrl & en & (cnt > win);
   assign low_load  = wr.ctrl & en_next & ~bus_wdata[CNT_W-1];
   assign timeout   = en & tick & ~wr.ctrl & (cnt == LOW_EDGE);
   assign fire      = too_early | low_load | timeout;
   assign flag_set  = tick & ~wr.ctrl & (cnt == WARN_EDGE);

   winwdt_tick #(.FIXED_DIV(FIXED_DIV), .TB_W(TB_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .restart(wr.ctrl | fire), .tb(tb), .tick(tick));

   winwdt_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .clr(fire), .tick(tick),
      .load(wr.ctrl), .load_val(bus_wdata[CNT_W-1:0]), .cnt(cnt));

   winwdt_regs #(.CNT_W(CNT_W), .TB_W(TB_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .clr(fire),
      .en_set(wr.ctrl & bus_wdata[EN_BIT]),
      .cfg_wr(wr.cfg), .cfg_win(bus_wdata[CNT_W-1:0]),
      .cfg_tb(bus_wdata[TB_LSB +: TB_W]), .cfg_ewi(bus_wdata[EWI_BIT]),
      .stat_wr(wr.stat), .stat_bit(bus_wdata[0]), .flag_set(flag_set),
      .en(en), .win(win), .tb(tb), .ewi(ewi), .flag(flag));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_req <= 1'b0;
      else        rst_req <= fire;
   end

   assign irq = flag & ewi;

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         REG_CTRL: bus_rdata[CNT_W:0] = {en, cnt};
         REG_CFG:  bus_rdata[EWI_BIT:0] = {ewi, tb, win};
         REG_STAT: bus_rdata[0] = flag;
         default:  bus_rdata = '0;
      endcase
   end

   if (DATA_W > USED_W) begin : g_spare
      logic unused_wdata;
      assign unused_wdata = ^bus_wdata[DATA_W-1:USED_W];
   end

   assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);
   assert_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (!en && (cnt == '1) && (win == '1) && !flag));
   assert_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag && ewi));
   assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !(wr.ctrl && bus_wdata[EN_BIT])) |=> !rst_req);
endmodule

// File: tb/sim_winwdt_top.sv
module sim_winwdt_top;
   localparam int CLK_NS = 10;
   localparam int FDIV   = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [15:0] bus_wdata = 16'd0;
   logic [15:0] bus_rdata;
   logic        rst_req, irq;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   winwdt_top #(.FIXED_DIV(FDIV)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req), .irq(irq));

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [15:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic wait_edges(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [15:0] v;
      int p;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      peek(2'd0, v); check("R1 ctrl", v, 16'h007F);
      peek(2'd1, v); check("R1 cfg", v, 16'h007F);
      peek(2'd2, v); check("R1 stat", v, 16'h0000);
      check("R1 rst_req", {15'd0, rst_req}, 16'd0);
      check("R1 irq", {15'd0, irq}, 16'd0);

      // R2 and R7: decrement period for every time-base value, counted from the load
      for (int t = 0; t < 4; t++) begin
         p = FDIV << t;
         wr(2'd1, 16'(t << 7) | 16'h007F);
         wr(2'd0, 16'h007F);
         wait_edges(p - 1);
         peek(2'd0, v); check("R2 before tick", v, 16'h007F);
         wait_edges(1);
         peek(2'd0, v); check("R2 at tick", v, 16'h007E);
      end

      // R3: full sweep through the wrap while disabled
      wr(2'd1, 16'h007F);
      wr(2'd0, 16'h007F);
      for (int k = 1; k <= 130; k++) begin
         wait_edges(FDIV);
         peek(2'd0, v); check("R3 sweep", v, 16'((8'h7F - k) & 8'h7F));
         check("R3 no reset", {15'd0, rst_req}, 16'd0);
      end
      peek(2'd2, v); check("R10 flag after sweep", v, 16'h0001);
      wr(2'd2, 16'h0000);

      // R10 and R11: flag set, sticky against writing 1, cleared by writing 0
      wr(2'd0, 16'h0041);
      wait_edges(FDIV);
      peek(2'd2, v); check("R10 set at 0x40", v, 16'h0001);
      check("R11 irq masked", {15'd0, irq}, 16'd0);
      wr(2'd2, 16'h0001);
      peek(2'd2, v); check("R10 write 1 ignored", v, 16'h0001);
      wr(2'd1, 16'h027F);
      check("R11 irq on", {15'd0, irq}, 16'd1);
      wr(2'd2, 16'h0000);
      peek(2'd2, v); check("R10 cleared", v, 16'h0000);
      check("R11 irq off", {15'd0, irq}, 16'd0);
      wr(2'd1, 16'h007F);

      // R4: the enable is one-way
      wr(2'd0, 16'h00FF);
      peek(2'd0, v); check("R4 set", v, 16'h00FF);
      wr(2'd0, 16'h007F);
      peek(2'd0, v); check("R4 write 0 ignored", v, 16'h00FF);
      check("R4 no reset", {15'd0, rst_req}, 16'd0);

      // R6 and R9: refresh above the window
      wr(2'd1, 16'h0050);
      wr(2'd0, 16'h00FF);
      check("R6 early refresh", {15'd0, rst_req}, 16'd1);
      peek(2'd0, v); check("R9 ctrl", v, 16'h007F);
      peek(2'd1, v); check("R9 cfg", v, 16'h007F);
      peek(2'd2, v); check("R9 stat", v, 16'h0000);
      wait_edges(1);
      check("R5 one clock", {15'd0, rst_req}, 16'd0);

      // R7: refresh inside the window
      wr(2'd0, 16'h00D2);
      wr(2'd1, 16'h0055);
      wr(2'd0, 16'h00F0);
      check("R7 no reset", {15'd0, rst_req}, 16'd0);
      peek(2'd0, v); check("R7 loaded", v, 16'h00F0);
      wait_edges(FDIV - 1);
      peek(2'd0, v); check("R7 prescaler restarted", v, 16'h00F0);
      wait_edges(1);
      peek(2'd0, v); check("R7 first tick", v, 16'h00EF);

      // R8: a load with bit 6 clear while enabled
      wr(2'd1, 16'h007F);
      wr(2'd0, 16'h00BF);
      check("R8 low load", {15'd0, rst_req}, 16'd1);
      wait_edges(1);
      wr(2'd0, 16'h003F);
      check("R8 disabled low load", {15'd0, rst_req}, 16'd0);
      peek(2'd0, v); check("R8 disabled loads", v, 16'h003F);

      // R5: timeout
      wr(2'd1, 16'h027F);
      wr(2'd0, 16'h00C2);
      wait_edges(FDIV);
      peek(2'd0, v); check("R5 at 0x41", v, 16'h00C1);
      wait_edges(FDIV);
      check("R11 warning irq", {15'd0, irq}, 16'd1);
      wait_edges(FDIV - 1);
      check("R5 not yet", {15'd0, rst_req}, 16'd0);
      peek(2'd0, v); check("R5 holds 0x40", v, 16'h00C0);
      wait_edges(1);
      check("R5 timeout", {15'd0, rst_req}, 16'd1);
      peek(2'd0, v); check("R9 after timeout", v, 16'h007F);
      check("R9 irq cleared", {15'd0, irq}, 16'd0);
      wait_edges(1);
      check("R5 pulse ends", {15'd0, rst_req}, 16'd0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule